// File: doc/BRIEF.md
# Sprite Attribute DMA Engine

This block fills the 160-byte object attribute memory (40 sprite entries of four bytes) from a block of system memory that the CPU picks. The CPU writes a page number into the engine's start register; the page number becomes the upper byte of the source address, so a source block always starts on a 256-byte boundary. The engine then issues one system-bus read per clock and writes each returned byte into attribute memory one clock later, at the same offset from the attribute memory base (0xFE00).

Only pages 0x80 through 0xDF are accepted as sources. A start value outside that window is dropped and changes nothing. A valid start value written while a copy is running abandons that copy and begins again at byte 0 from the new page. While the engine owns either bus it raises `busy`, which the surrounding system uses to hold off CPU accesses. The engine copies bytes in order and does not reorder them, so each sprite entry keeps its four bytes in place: vertical position, horizontal position, tile number, then flags.

Top module: `spr_dma_engine`

## Requirements
- R1: After reset, `busy`, `src_req` and `oam_we` are low and stay low until a valid start value is written.
- R2: When `start_wr` is high at a clock edge and `start_page` is in 0x80..0xDF, `src_req` is high in the next cycle with `src_addr` = {start_page, 0x00}.
- R3: While a copy runs, reads go out one per cycle at ascending addresses {page, i} for i = 0 to 159. A read is never issued outside the source window.
- R4: The source returns read data in the cycle after the read. In that cycle the engine asserts `oam_we` with `oam_addr` = 0xFE00 + i and `oam_wdata` equal to `src_rdata`.
- R5: A copy that nothing interrupts performs exactly 160 attribute writes, at 0xFE00 through 0xFE9F in order, and never writes outside that range.
- R6: `busy` is high from the cycle after the accepted start write through the cycle of the last attribute write (161 cycles), and low in the cycle after that.
- R7: A start value outside 0x80..0xDF written while idle is ignored: `busy`, `src_req` and `oam_we` stay low.
- R8: A start value outside 0x80..0xDF written during a copy has no effect. The copy goes on with the same page, sequence and timing.
- R9: A valid start value written during a copy restarts it. In the next cycle no attribute write occurs, the read address is {new page, 0x00}, and the following 160 writes come from the new page.
- R10: After a full copy, attribute byte 4n+k (n = 0..39, k = 0..3) holds source byte 4n+k. This keeps the order vertical position, horizontal position, tile number, flags in every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_wr | input | 1 | CPU write strobe for the start register |
| start_page | input | 8 | Source page (upper address byte) written with the strobe |
| busy | output | 1 | Engine owns the buses; CPU accesses must wait |
| src_req | output | 1 | System-bus read request |
| src_addr | output | 16 | System-bus read address |
| src_rdata | input | 8 | Read data, valid one cycle after the request |
| oam_we | output | 1 | Attribute memory write enable |
| oam_addr | output | 16 | Attribute memory write address |
| oam_wdata | output | 8 | Attribute memory write data |

## Verification
The first read is due one cycle after the edge that accepts the start write. Each write follows its read by exactly one cycle, and `busy` falls 161 cycles after the accepting edge. The bench drives inputs on falling edges and samples every output on the next falling edge, counting falling edges from the start write. Each write is checked against the index it should carry at that count, and busy cycles and writes are totalled for each copy. For a restart or an ignored start, the injection happens at a known count. The expected sequence then either resets to index 0 of the new page from the next cycle on, or carries on unchanged.

// File: rtl/spr_dma_pkg.sv
// Shared types and helpers for the sprite attribute DMA engine.
// Assumes: 16-bit system addresses, byte-wide data.
package spr_dma_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [15:0] addr_t;

    // True when a page number falls inside the accepted source window.
    function automatic logic page_in_window(input byte_t page, input byte_t lo, input byte_t hi);
        return (page >= lo) && (page <= hi);
    endfunction

endpackage

// File: rtl/spr_dma_page_gate.sv
// Start qualifier: turns a CPU write of a page number into a start pulse,
// but only when the page lies inside the source window.
// Assumes: start_wr is a single-cycle strobe from the CPU register decode.
module spr_dma_page_gate
    import spr_dma_pkg::*;
#(
    parameter byte_t PAGE_MIN = 8'h80,
    parameter byte_t PAGE_MAX = 8'hDF
) (
    input  logic  start_wr,
    input  byte_t start_page,
    output logic  start_ok
);

    // Accept the write only for pages inside the window.
    always_comb begin
        start_ok = start_wr && page_in_window(start_page, PAGE_MIN, PAGE_MAX);
    end

endmodule

// File: rtl/spr_dma_rd_seq.sv
// Read sequencer: holds the latched source page and steps a byte index
// from 0 to XFER_LEN-1, one read per cycle. A start restarts it at 0.
// Assumes: the source bus accepts a read every cycle.
module spr_dma_rd_seq
    import spr_dma_pkg::*;
#(
    parameter int XFER_LEN = 160,
    parameter int IDX_W    = $clog2(XFER_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  byte_t            page_in,
    output logic             rd_act,
    output logic [IDX_W-1:0] rd_idx,
    output byte_t            page
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

    // Latch page on start, then advance the index until the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act <= 1'b0;
            rd_idx <= '0;
            page   <= '0;
        end else if (start) begin
            rd_act <= 1'b1;
            rd_idx <= '0;
            page   <= page_in;
        end else if (rd_act) begin
            if (rd_idx == LAST_IDX) begin
                rd_act <= 1'b0;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spr_dma_wr_stage.sv
// Write stage: delays the read index by one cycle to line up with the
// returned read data. A flush drops the byte in flight.
// Assumes: source read latency is exactly one cycle.
module spr_dma_wr_stage #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rd_act,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             wr_vld,
    output logic [IDX_W-1:0] wr_idx
);

    // Track the read issued last cycle; discard it on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_vld <= rd_act && !flush;
            wr_idx <= rd_idx;
        end
    end

endmodule

// File: rtl/spr_dma_engine.sv
// Sprite attribute DMA engine top. A CPU write of a source page starts a
// copy of N_ENTRIES*ENTRY_BYTES bytes from {page, 8'h00} to DST_BASE, one
// byte per clock, read and write pipelined one cycle apart.
// Assumes: src_rdata is valid the cycle after src_req; the attribute memory
// takes a write every cycle.
module spr_dma_engine
    import spr_dma_pkg::*;
#(
    parameter int    N_ENTRIES   = 40,
    parameter int    ENTRY_BYTES = 4,
    parameter byte_t PAGE_MIN    = 8'h80,
    parameter byte_t PAGE_MAX    = 8'hDF,
    parameter addr_t DST_BASE    = 16'hFE00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic [7:0]  start_page,
    output logic        busy,
    output logic        src_req,
    output logic [15:0] src_addr,
    input  logic [7:0]  src_rdata,
    output logic        oam_we,
    output logic [15:0] oam_addr,
    output logic [7:0]  oam_wdata
);

    localparam int XFER_LEN = N_ENTRIES * ENTRY_BYTES;
    localparam int IDX_W    = $clog2(XFER_LEN);

    logic             start_ok;
    logic             rd_act;
    logic [IDX_W-1:0] rd_idx;
    byte_t            page_q;
    logic             wr_vld;
    logic [IDX_W-1:0] wr_idx;

    spr_dma_page_gate #(
        .PAGE_MIN (PAGE_MIN),
        .PAGE_MAX (PAGE_MAX)
    ) u_gate (
        .start_wr   (start_wr),
        .start_page (start_page),
        .start_ok   (start_ok)
    );

    spr_dma_rd_seq #(
        .XFER_LEN (XFER_LEN),
        .IDX_W    (IDX_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_ok),
        .page_in (start_page),
        .rd_act  (rd_act),
        .rd_idx  (rd_idx),
        .page    (page_q)
    );

    spr_dma_wr_stage #(
        .IDX_W (IDX_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (start_ok),
        .rd_act (rd_act),
        .rd_idx (rd_idx),
        .wr_vld (wr_vld),
        .wr_idx (wr_idx)
    );

    // Drive both bus sides from the sequencer and write stage.
    always_comb begin
        src_req   = rd_act;
        src_addr  = {page_q, 8'h00} + 16'(rd_idx);
        oam_we    = wr_vld;
        oam_addr  = DST_BASE + 16'(wr_idx);
        oam_wdata = src_rdata;
        busy      = rd_act || wr_vld;
    end

endmodule

// File: rtl/spr_dma_chk.sv
// Protocol checker for spr_dma_engine, attached by bind below.
// Assumes: the engine's default transfer size and window, passed in as parameters.
module spr_dma_chk #(
    parameter int          XFER_LEN = 160,
    parameter logic [7:0]  PAGE_MIN = 8'h80,
    parameter logic [7:0]  PAGE_MAX = 8'hDF,
    parameter logic [15:0] DST_BASE = 16'hFE00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_wr,
    input logic [7:0]  start_page,
    input logic        busy,
    input logic        src_req,
    input logic [15:0] src_addr,
    input logic        oam_we,
    input logic [15:0] oam_addr
);

    localparam logic [7:0] LAST = 8'(XFER_LEN - 1);

    logic go;
    // Valid start as seen at the ports.
    always_comb go = start_wr && (start_page >= PAGE_MIN) && (start_page <= PAGE_MAX);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_req && !oam_we));

    p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (src_req && busy && src_addr == {$past(start_page), 8'h00}));

    p_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !go && src_addr[7:0] != LAST) |=> (src_req && src_addr == $past(src_addr) + 16'd1));

    p_src_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        src_req |-> (src_addr[15:8] >= PAGE_MIN && src_addr[15:8] <= PAGE_MAX));

    p_write_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !go) |=> (oam_we && oam_addr == DST_BASE + {8'h00, $past(src_addr[7:0])}));

    p_dst_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oam_we |-> (oam_addr >= DST_BASE && oam_addr <= DST_BASE + 16'(LAST)));

    p_busy_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oam_we && oam_addr == DST_BASE + 16'(LAST) && !src_req && !go) |=> !busy);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> (!oam_we && src_addr[7:0] == 8'h00));

endmodule

bind spr_dma_engine spr_dma_chk #(
    .XFER_LEN (N_ENTRIES * ENTRY_BYTES),
    .PAGE_MIN (PAGE_MIN),
    .PAGE_MAX (PAGE_MAX),
    .DST_BASE (DST_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr   (start_wr),
    .start_page (start_page),
    .busy       (busy),
    .src_req    (src_req),
    .src_addr   (src_addr),
    .oam_we     (oam_we),
    .oam_addr   (oam_addr)
);

// File: tb/sim_spr_dma_engine.sv
module sim_spr_dma_engine;

    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 1'b0;
    logic [7:0]  start_page = 8'h00;
    logic        busy, src_req, oam_we;
    logic [15:0] src_addr, oam_addr;
    logic [7:0]  src_rdata, oam_wdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0] oam_mem [LEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_page(start_page),
        .busy(busy), .src_req(src_req), .src_addr(src_addr), .src_rdata(src_rdata),
        .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata)
    );

    // Source memory pattern, computed from the address.
    function automatic logic [7:0] byte_at(input logic [15:0] a);
        return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    // Source model with one cycle of read latency.
    always_ff @(posedge clk) begin
        if (src_req) src_rdata <= byte_at(src_addr);
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Start a copy, optionally write the start register again at count inj_at,
    // then watch until busy falls. Returns counts after the last accepted start.
    task automatic run_xfer(input logic [7:0] page, input int inj_at, input logic [7:0] inj_page,
                            output int busy_n, output int wr_n, output int seq_err,
                            output logic [7:0] final_page);
        int idx;
        logic [7:0] cur;
        for (int k = 0; k < LEN; k++) oam_mem[k] = 8'h00;
        @(negedge clk);
        start_wr = 1'b1;
        start_page = page;
        @(negedge clk);
        start_wr = 1'b0;
        cur = page; idx = 0; busy_n = 0; wr_n = 0; seq_err = 0;
        for (int n = 1; n < 600; n++) begin
            if (!busy) break;
            busy_n++;
            if (oam_we) begin
                if (oam_addr != 16'hFE00 + 16'(idx) ||
                    oam_wdata != byte_at({cur, 8'h00} + 16'(idx))) begin
                    if (seq_err == 0)
                        $display("FAIL R4 write %0d: actual addr %h data %h expected addr %h data %h",
                                 idx, oam_addr, oam_wdata, 16'hFE00 + 16'(idx),
                                 byte_at({cur, 8'h00} + 16'(idx)));
                    seq_err++;
                end
                if (oam_addr >= 16'hFE00 && oam_addr < 16'hFE00 + 16'(LEN))
                    oam_mem[oam_addr - 16'hFE00] = oam_wdata;
                wr_n++;
                idx++;
            end
            if (n == inj_at) begin
                start_wr = 1'b1;
                start_page = inj_page;
                if (inj_page >= 8'h80 && inj_page <= 8'hDF) begin
                    cur = inj_page; idx = 0; busy_n = 0; wr_n = 0;
                end
            end
            @(negedge clk);
            start_wr = 1'b0;
        end
        final_page = cur;
    endtask

    task automatic check_copy(input string tag, input logic [7:0] page, input int busy_n,
                              input int wr_n, input int seq_err);
        int bad;
        chk(busy_n == LEN + 1, "R6", {tag, " busy cycles"}, busy_n, LEN + 1);
        chk(wr_n == LEN, "R5", {tag, " write count"}, wr_n, LEN);
        chk(seq_err == 0, "R3", {tag, " read/write sequence errors"}, seq_err, 0);
        bad = 0;
        for (int e = 0; e < LEN / 4; e++)
            for (int k = 0; k < 4; k++)
                if (oam_mem[4*e+k] != byte_at({page, 8'h00} + 16'(4*e+k))) bad++;
        chk(bad == 0, "R10", {tag, " entry bytes wrong"}, bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int bn, wn, se;
        logic [7:0] fp;
        repeat (3) @(negedge clk);
        chk(!busy && !src_req && !oam_we, "R1", "outputs in reset", {busy, src_req, oam_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !src_req && !oam_we, "R1", "outputs idle after reset", {busy, src_req, oam_we}, 0);

        // R7: every out-of-window page is ignored while idle.
        for (int v = 0; v < 256; v++) begin
            if (v >= 8'h80 && v <= 8'hDF) continue;
            start_wr = 1'b1;
            start_page = 8'(v);
            @(negedge clk);
            start_wr = 1'b0;
            chk(!busy && !src_req && !oam_we, "R7", $sformatf("page %0h ignored", v),
                {busy, src_req, oam_we}, 0);
            @(negedge clk);
        end

        // R2: first read is due the cycle after the accepting edge.
        @(negedge clk);
        start_wr = 1'b1;
        start_page = 8'hC3;
        @(negedge clk);
        start_wr = 1'b0;
        chk(src_req && busy, "R2", "read issued after start", {src_req, busy}, 3);
        chk(src_addr == 16'hC300, "R2", "first read address", src_addr, 16'hC300);
        repeat (170) @(negedge clk);

        // R3 R4 R5 R6 R10: every valid page.
        for (int p = 8'h80; p <= 8'hDF; p++) begin
            run_xfer(8'(p), -1, 8'h00, bn, wn, se, fp);
            check_copy($sformatf("page %0h", p), 8'(p), bn, wn, se);
        end

        // R9: valid restarts at several points.
        run_xfer(8'h90, 50, 8'hA7, bn, wn, se, fp);
        chk(fp == 8'hA7, "R9", "restart page taken", fp, 8'hA7);
        check_copy("R9 restart mid", 8'hA7, bn, wn, se);
        run_xfer(8'hDF, 1, 8'h80, bn, wn, se, fp);
        check_copy("R9 restart early", 8'h80, bn, wn, se);
        run_xfer(8'hB2, 160, 8'hB3, bn, wn, se, fp);
        check_copy("R9 restart at last write", 8'hB3, bn, wn, se);

        // R8: out-of-window writes during a copy change nothing.
        run_xfer(8'h88, 70, 8'hE0, bn, wn, se, fp);
        check_copy("R8 ignore E0", 8'h88, bn, wn, se);
        run_xfer(8'hD0, 12, 8'h7F, bn, wn, se, fp);
        check_copy("R8 ignore 7F", 8'hD0, bn, wn, se);

        @(negedge clk);
        chk(!busy && !src_req && !oam_we, "R1", "idle at end", {busy, src_req, oam_we}, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule